// File: doc/BRIEF.md
# Pattern Memory Test Engine

The block is a self-contained memory test engine. After a start pulse it fills every word of an attached single-port synchronous memory with a data pattern, then reads every word back and compares it with the value it ought to hold. It does this for four pattern types in a fixed order and then stops with a done flag raised.

Expected data is never stored. The pattern generator is rerun from a saved state during the read pass. Reads are grouped into blocks of 16 consecutive words. When the last word of a block has been checked, a one-cycle hook asks external logic (for example an ECC status reader) to inspect that block.

A mismatch produces a one-cycle report carrying the address, the expected word and the bad-bit mask. A check-disable input silences both the comparison and the block hook without changing the traversal. A loop input keeps the engine re-reading the current pattern so that a failing location can be watched on a scope.

The error report and the block hook are single-cycle pulses with no ready input. The engine never stalls on them, so a consumer must capture them in the cycle they appear. On the memory side the port has no back-pressure. A write completes in the cycle `mem_we` is high. Read data must appear on `mem_rdata` in the cycle after `mem_re`.

Top module: `pmt_engine`

## Requirements
- R1: A write pass drives `mem_we` for one cycle on each address from 0 up to 2^ADDR_W-1 in ascending order, on consecutive cycles. A read pass drives `mem_re` on each address in the same ascending order, one read every two cycles, with one extra cycle after each 16-word block. `mem_we` and `mem_re` are never high together.
- R2: The pattern select codes are: 0 gives word 0x0000, 1 gives 0xFFFF, 2 gives the LFSR sequence, and 3 gives the address zero-extended to 16 bits.
- R3: The LFSR word for the first address equals the loaded seed. The seed is the `seed` input sampled at start, with 0x0000 replaced by 0x0001. Each following word is the previous word shifted left by one, with bit 0 set to the XOR of bits 15, 13, 12 and 10.
- R4: Before each read pass the generator is restored to the state it held before that pattern's write pass. The expected word at every address therefore equals the word that was written there.
- R5: When a read word differs from its expected word, `err_valid` is high for exactly one cycle, two cycles after the `mem_re` cycle. In that cycle `err_addr` holds the address, `err_expect` the expected word, and `err_mask` the XOR of the read word and the expected word. `fail` then goes high.
- R6: After the 16th word of a block has been checked, and before the next block's first read, `grp_chk` is high for one cycle and `grp_base` holds the block's first address (low 4 bits zero).
- R7: While `chk_disable` is high, `err_valid` and `grp_chk` stay low. Writes, reads and the cycle count are unchanged.
- R8: The patterns run in the order 0, 1, 2, 3. After the read pass of pattern 3, `done` goes high and no further memory access occurs.
- R9: If `loop_mode` is high at the end of a read pass, the engine reads and checks the same pattern again from address 0 without rewriting the memory.
- R10: `done` and `fail` stay high until a start is accepted. A start is accepted only when the engine is idle or done. A start pulse while busy changes nothing.
- R11: After reset, `busy`, `done`, `fail`, `err_valid`, `grp_chk`, `mem_we` and `mem_re` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken when idle or done) |
| loop_mode | input | 1 | Repeat the read pass of the current pattern |
| chk_disable | input | 1 | Suppress error reports and block hooks |
| seed | input | 16 | LFSR seed sampled at start |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe; data expected next cycle |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | All patterns finished (sticky) |
| grp_chk | output | 1 | Block status check hook pulse |
| grp_base | output | ADDR_W | First address of the block just checked |
| err_valid | output | 1 | Mismatch report pulse |
| err_addr | output | ADDR_W | Failing address |
| err_expect | output | 16 | Expected word |
| err_mask | output | 16 | Bad-bit mask |
| fail | output | 1 | At least one mismatch this run (sticky) |

## Verification
The bound checker watches, on every cycle, the port-level rules. These are: exclusive read and write strobes, strictly ascending write addresses, block-aligned hook bases that follow a read and a check, no error report while checking is disabled, silence after done, and the stickiness of done and fail. Only the bench scenarios can show the data-level behaviour. That includes each pattern's exact words, which the bench regenerates from its own LFSR table. It also includes the expected values carried by injected stuck-bit errors in every pattern, the regeneration of the LFSR state across repeated loop passes, the pattern order, and the rule that a start pulse is ignored mid-run.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

  localparam int WORD_W = 16;
  localparam int GRP_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_CHECK,
    ST_GROUP,
    ST_DONE
  } pmt_state_e;

  typedef enum logic [1:0] {
    PAT_ZERO = 2'd0,
    PAT_ONES = 2'd1,
    PAT_LFSR = 2'd2,
    PAT_ADDR = 2'd3
  } pmt_pat_e;

  function automatic logic [WORD_W-1:0] lfsr_advance(input logic [WORD_W-1:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/pmt_patgen.sv
module pmt_patgen
  import pmt_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] seed,
  input  logic              save,
  input  logic              restore,
  input  logic              step,
  input  pmt_pat_e          pat_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] lfsr_q;
  logic [WORD_W-1:0] saved_q;
  logic [WORD_W-1:0] seed_fix;
  logic [WORD_W-1:0] addr_word;

  // an all-zero state would lock the register, so it is replaced
  assign seed_fix = (seed == '0) ? WORD_W'(1) : seed;

  generate
    if (ADDR_W >= WORD_W) begin : g_addr_trunc
      assign addr_word = addr[WORD_W-1:0];
    end else begin : g_addr_ext
      assign addr_word = {{(WORD_W-ADDR_W){1'b0}}, addr};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q  <= WORD_W'(1);
      saved_q <= WORD_W'(1);
    end else begin
      if (load) begin
        lfsr_q  <= seed_fix;
        saved_q <= seed_fix;
      end else begin
        if (restore)   lfsr_q <= saved_q;
        else if (step) lfsr_q <= lfsr_advance(lfsr_q);
        if (save)      saved_q <= lfsr_q;
      end
    end
  end

  always_comb begin
    unique case (pat_sel)
      PAT_ZERO: word = '0;
      PAT_ONES: word = '1;
      PAT_LFSR: word = lfsr_q;
      PAT_ADDR: word = addr_word;
      default:  word = '0;
    endcase
  end

endmodule

// File: rtl/pmt_ctrl.sv
module pmt_ctrl
  import pmt_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              loop_mode,
  output logic [ADDR_W-1:0] addr,
  output pmt_pat_e          pat,
  output logic              start_acc,
  output logic              gen_save,
  output logic              gen_restore,
  output logic              gen_step,
  output logic              wr_en,
  output logic              rd_en,
  output logic              chk_slot,
  output logic              grp_slot,
  output logic              busy,
  output logic              done
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [GRP_W-1:0]  GRP_LAST  = '1;

  pmt_state_e state_q;
  logic [ADDR_W-1:0] addr_q;
  pmt_pat_e pat_q;
  logic at_last;
  logic pass_end;

  assign at_last   = (addr_q == LAST_ADDR);
  assign pass_end  = (state_q == ST_GROUP) && at_last;
  assign start_acc = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      pat_q   <= PAT_ZERO;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state_q <= ST_WRITE;
            addr_q  <= '0;
            pat_q   <= PAT_ZERO;
          end
        end
        ST_WRITE: begin
          if (at_last) begin
            addr_q  <= '0;
            state_q <= ST_READ;
          end else begin
            addr_q  <= addr_q + 1'b1;
          end
        end
        ST_READ: state_q <= ST_CHECK;
        ST_CHECK: begin
          if (addr_q[GRP_W-1:0] == GRP_LAST) begin
            state_q <= ST_GROUP;
          end else begin
            addr_q  <= addr_q + 1'b1;
            state_q <= ST_READ;
          end
        end
        ST_GROUP: begin
          if (at_last) begin
            addr_q <= '0;
            if (loop_mode) begin
              state_q <= ST_READ;
            end else if (pat_q == PAT_ADDR) begin
              state_q <= ST_DONE;
            end else begin
              pat_q   <= pmt_pat_e'(pat_q + 2'd1);
              state_q <= ST_WRITE;
            end
          end else begin
            addr_q  <= addr_q + 1'b1;
            state_q <= ST_READ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign gen_restore = ((state_q == ST_WRITE) && at_last) || (pass_end && loop_mode);
  assign gen_save    = pass_end && !loop_mode && (pat_q != PAT_ADDR);
  assign gen_step    = (pat_q == PAT_LFSR) &&
                       ((state_q == ST_WRITE) || (state_q == ST_CHECK));

  assign addr     = addr_q;
  assign pat      = pat_q;
  assign wr_en    = (state_q == ST_WRITE);
  assign rd_en    = (state_q == ST_READ);
  assign chk_slot = (state_q == ST_CHECK);
  assign grp_slot = (state_q == ST_GROUP);
  assign busy     = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done     = (state_q == ST_DONE);

endmodule

// File: rtl/pmt_cmp.sv
module pmt_cmp
  import pmt_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              chk_en,
  input  logic [WORD_W-1:0] rdata,
  input  logic [WORD_W-1:0] expect_w,
  input  logic [ADDR_W-1:0] addr,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr,
  output logic [WORD_W-1:0] err_expect,
  output logic [WORD_W-1:0] err_mask,
  output logic              fail
);

  logic [WORD_W-1:0] diff;
  logic hit;

  assign diff = rdata ^ expect_w;
  assign hit  = chk_en && (diff != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_valid  <= 1'b0;
      err_addr   <= '0;
      err_expect <= '0;
      err_mask   <= '0;
      fail       <= 1'b0;
    end else begin
      err_valid <= hit;
      if (hit) begin
        err_addr   <= addr;
        err_expect <= expect_w;
        err_mask   <= diff;
      end
      if (clear)    fail <= 1'b0;
      else if (hit) fail <= 1'b1;
    end
  end

endmodule

// File: rtl/pmt_engine.sv
module pmt_engine
  import pmt_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              loop_mode,
  input  logic              chk_disable,
  input  logic [15:0]       seed,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [15:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              grp_chk,
  output logic [ADDR_W-1:0] grp_base,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr,
  output logic [15:0]       err_expect,
  output logic [15:0]       err_mask,
  output logic              fail
);

  logic [ADDR_W-1:0] addr;
  pmt_pat_e pat;
  logic start_acc, gen_save, gen_restore, gen_step;
  logic chk_slot, grp_slot;
  logic [WORD_W-1:0] word;

  pmt_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .loop_mode(loop_mode),
    .addr(addr), .pat(pat), .start_acc(start_acc),
    .gen_save(gen_save), .gen_restore(gen_restore), .gen_step(gen_step),
    .wr_en(mem_we), .rd_en(mem_re), .chk_slot(chk_slot), .grp_slot(grp_slot),
    .busy(busy), .done(done)
  );

  pmt_patgen #(.ADDR_W(ADDR_W)) gen_i (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .seed(seed),
    .save(gen_save), .restore(gen_restore), .step(gen_step),
    .pat_sel(pat), .addr(addr), .word(word)
  );

  pmt_cmp #(.ADDR_W(ADDR_W)) cmp_i (
    .clk(clk), .rst_n(rst_n), .clear(start_acc),
    .chk_en(chk_slot && !chk_disable), .rdata(mem_rdata), .expect_w(word),
    .addr(addr), .err_valid(err_valid), .err_addr(err_addr),
    .err_expect(err_expect), .err_mask(err_mask), .fail(fail)
  );

  assign mem_addr  = addr;
  assign mem_wdata = word;
  assign grp_chk   = grp_slot && !chk_disable;
  assign grp_base  = {addr[ADDR_W-1:GRP_W], {GRP_W{1'b0}}};

endmodule

// File: rtl/pmt_engine_chk.sv
module pmt_engine_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              chk_disable,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic              done,
  input logic              grp_chk,
  input logic [ADDR_W-1:0] grp_base,
  input logic              err_valid,
  input logic              fail
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R1

  AST_WRITE_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R1

  AST_ERR_TAKES_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> fail); // R5

  AST_NO_ERR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> !$past(chk_disable)); // R7

  AST_GRP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    grp_chk |-> (grp_base[3:0] == 4'd0)); // R6

  AST_GRP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    grp_chk |-> ($past(mem_re, 2) && !chk_disable)); // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_we && !mem_re)); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R10

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail); // R10

endmodule

bind pmt_engine pmt_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .chk_disable(chk_disable),
  .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .done(done),
  .grp_chk(grp_chk), .grp_base(grp_base), .err_valid(err_valid), .fail(fail)
);

// File: tb/pmt_engine_tb_top.sv
module pmt_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int N  = 1 << AW;
  localparam int G  = N / 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, loop_mode = 1'b0, chk_disable = 1'b0;
  logic [15:0] seed = 16'h0;
  logic [AW-1:0] mem_addr, grp_base, err_addr;
  logic [15:0] mem_wdata, mem_rdata, err_expect, err_mask;
  logic mem_we, mem_re, busy, done, grp_chk, err_valid, fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmt_engine #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .loop_mode(loop_mode),
    .chk_disable(chk_disable), .seed(seed), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .grp_chk(grp_chk),
    .grp_base(grp_base), .err_valid(err_valid), .err_addr(err_addr),
    .err_expect(err_expect), .err_mask(err_mask), .fail(fail)
  );

  // memory model with an optional stuck-bit fault on read
  logic [15:0] mem [N];
  logic fault_en = 1'b0;
  int fault_a = 0;
  logic [15:0] fault_m = 16'h0100;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr] ^
                 ((fault_en && int'(mem_addr) == fault_a) ? fault_m : 16'h0);
  end

  int n_cmp = 0, n_bad = 0;
  logic [15:0] lfsr_tab [N];
  int wcnt, rcnt, gcnt, ecnt, last_ra;
  logic mon_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] bpat(input int p, input int a);
    case (p)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return lfsr_tab[a];
      default: return 16'(a);
    endcase
  endfunction

  task automatic build_tab(input logic [15:0] s0);
    logic [15:0] s;
    s = (s0 == 16'h0) ? 16'h0001 : s0;
    for (int i = 0; i < N; i++) begin
      lfsr_tab[i] = s;
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (mem_we) begin
        chk(int'(mem_addr) == wcnt % N, "R1 write address", 32'(mem_addr), 32'(wcnt % N));
        chk(mem_wdata == bpat(wcnt / N, wcnt % N), (wcnt / N == 2) ? "R3 lfsr word" : "R2 pattern word",
            32'(mem_wdata), 32'(bpat(wcnt / N, wcnt % N)));
        wcnt++;
      end
      if (mem_re) begin
        chk(int'(mem_addr) == rcnt % N, "R1 read address", 32'(mem_addr), 32'(rcnt % N));
        last_ra = int'(mem_addr);
        rcnt++;
      end
      if (grp_chk) begin
        chk(int'(grp_base) == (last_ra & ~15) && (last_ra % 16) == 15, "R6 group base",
            32'(grp_base), 32'(last_ra & ~15));
        gcnt++;
      end
      if (err_valid) begin
        chk(int'(err_addr) == fault_a, "R5 err address", 32'(err_addr), 32'(fault_a));
        chk(err_expect == bpat((wcnt - 1) / N, fault_a), "R4 err expected",
            32'(err_expect), 32'(bpat((wcnt - 1) / N, fault_a)));
        chk(err_mask == fault_m, "R5 err mask", 32'(err_mask), 32'(fault_m));
        ecnt++;
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic kick(input logic [15:0] s);
    wcnt = 0; rcnt = 0; gcnt = 0; ecnt = 0; last_ra = 0;
    seed = s;
    build_tab(s);
    mon_on = 1'b1;
    start = 1'b1;
    tick(1);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int t;
    t = 0;
    while (!done && t < 20000) begin
      tick(1);
      t++;
    end
    chk(done == 1'b1, tag, 32'(done), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired R8 actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    chk({busy, done, fail, err_valid, grp_chk, mem_we, mem_re} == 7'b0,
        "R11 reset outputs", 32'({busy, done, fail, err_valid, grp_chk, mem_we, mem_re}), 32'd0);
    rst_n = 1'b1;
    tick(2);

    // clean run
    kick(16'hACE1);
    wait_done("R8 clean run done");
    chk(wcnt == 4 * N, "R8 writes", 32'(wcnt), 32'(4 * N));
    chk(rcnt == 4 * N, "R1 reads", 32'(rcnt), 32'(4 * N));
    chk(gcnt == 4 * G, "R6 group hooks", 32'(gcnt), 32'(4 * G));
    chk(ecnt == 0 && !fail, "R5 no errors", 32'(ecnt), 32'd0);
    tick(20);
    chk(done == 1'b1, "R10 done sticky", 32'(done), 32'd1);
    chk(wcnt == 4 * N && rcnt == 4 * N, "R8 quiet after done", 32'(wcnt + rcnt), 32'(8 * N));

    // stuck bit in every pattern
    fault_en = 1'b1; fault_a = 37;
    kick(16'h1234);
    chk(done == 1'b0, "R10 done cleared by start", 32'(done), 32'd0);
    wait_done("R8 fault run done");
    chk(ecnt == 4, "R5 one report per pattern", 32'(ecnt), 32'd4);
    tick(15);
    chk(fail == 1'b1, "R10 fail sticky", 32'(fail), 32'd1);
    kick(16'h1234);
    chk(fail == 1'b0, "R10 fail cleared by start", 32'(fail), 32'd0);
    wait_done("R8 second fault run done");

    // checking disabled
    chk_disable = 1'b1;
    kick(16'h5555);
    wait_done("R7 disabled run done");
    chk(ecnt == 0 && !fail, "R7 no error reports", 32'(ecnt), 32'd0);
    chk(gcnt == 0, "R7 no group hooks", 32'(gcnt), 32'd0);
    chk(rcnt == 4 * N && wcnt == 4 * N, "R7 traversal unchanged", 32'(rcnt + wcnt), 32'(8 * N));
    chk_disable = 1'b0;
    fault_en = 1'b0;

    // zero seed, start pulse while busy
    kick(16'h0000);
    tick(N + 10);
    start = 1'b1;
    tick(1);
    start = 1'b0;
    wait_done("R10 busy start ignored");
    chk(wcnt == 4 * N, "R10 writes after busy start", 32'(wcnt), 32'(4 * N));
    chk(lfsr_tab[0] == 16'h0001, "R3 zero seed", 32'(lfsr_tab[0]), 32'h1);

    // loop on the LFSR pattern
    fault_en = 1'b1; fault_a = 5;
    kick(16'hBEEF);
    while (wcnt < 3 * N) tick(1);
    loop_mode = 1'b1;
    while (rcnt < 5 * N + 8) tick(1);
    chk(wcnt == 3 * N, "R9 no rewrite while looping", 32'(wcnt), 32'(3 * N));
    loop_mode = 1'b0;
    wait_done("R9 loop exit done");
    chk(wcnt == 4 * N, "R9 writes total", 32'(wcnt), 32'(4 * N));
    chk(ecnt == 3 + (rcnt - 3 * N) / N, "R9 report per pass",
        32'(ecnt), 32'(3 + (rcnt - 3 * N) / N));
    chk(rcnt >= 6 * N, "R9 extra passes", 32'(rcnt), 32'(6 * N));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule